// File: doc/BRIEF.md
# Wrap-Around Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a two's complement stream by an integer factor and filters it on the way. Its sharp nulls suppress the bands that would otherwise alias onto the output. Input samples arrive with a one-cycle valid strobe, at most one per clock. Each one first passes through `ORDER` cascaded integrators running at the input rate. A rate picker then forwards one valid sample in every `RATE` and drops the rest. The survivors pass through `ORDER` cascaded comb stages with a differential delay of `DELAY` reduced-rate samples. Each result leaves with its own one-cycle valid strobe.

All internal registers and the output are `ACC_W = IN_W + clog2((RATE*DELAY)^ORDER)` bits wide. The integrators are allowed to overflow and wrap modulo 2^ACC_W without saturation. Because the combs take differences, the wrapped values still give the exact filter result, and that result always fits in `ACC_W` bits. The output is not rescaled, rounded or truncated. One clock drives everything, and the reset is synchronous and active high.

The rate picker is a two-state machine with a phase counter:

- `PH_KEEP`: the next valid sample is forwarded, and the counter is 0.
  - Transition *take*: a valid sample arrives and `RATE > 1`. The machine moves to `PH_DROP` and the counter becomes 1.
- `PH_DROP`: valid samples are discarded, and the counter is incremented on each one.
  - Transition *wrap*: a valid sample arrives while the counter is `RATE-1`. The machine returns to `PH_KEEP` and the counter becomes 0.
- Reset enters `PH_KEEP`.

Top module: `cic_wrap_decim`

## Requirements
- R1: While `rst` is high at a clock edge, every integrator, comb delay line and output register is cleared and the picker returns to `PH_KEEP`. During reset `out_vld` reads 0 and `out_smp` reads 0. After reset, an input sequence gives the same outputs as from power-up.
- R2: Integrators and combs change state only on cycles where their input strobe is high. Idle cycles (`in_vld` low) between samples have no effect on any output value.
- R3: Counting valid inputs from reset as 0, 1, 2 and so on, exactly the inputs whose index is a multiple of `RATE` produce an output. N valid inputs produce ceil(N/RATE) outputs.
- R4: Each output equals the exact cascade of `ORDER` integrators, decimation by `RATE`, and `ORDER` combs y[n] = x[n] - x[n-DELAY] on the reduced-rate stream. The comb history starts at zero after reset. For a unit impulse as the first input, the first output is 1.
- R5: Integrator overflow wraps modulo 2^ACC_W and never saturates. Under a long constant input c, the output settles to exactly c*(RATE*DELAY)^ORDER. This holds at both extremes, c = 2^(IN_W-1)-1 and c = -2^(IN_W-1).
- R6: `out_vld` is high for one cycle per result. It rises after the 2*ORDER+1-th rising edge, counting the edge that samples the kept input as the first.
- R7: The output is read as a signed two's complement value of `ACC_W` bits, with bit ACC_W-1 as the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least the input sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample strobe, one cycle per sample |
| in_smp | input | IN_W | Two's complement input sample |
| out_vld | output | 1 | Output sample strobe, one cycle per result |
| out_smp | output | ACC_W | Two's complement filtered, decimated sample |

## Verification
The embedded properties take for granted that `in_vld` is a clean 0 or 1 from the first clock edge and that reset is asserted before the first sample. The bench drives both from time zero. The single-pulse property on `out_vld` relies on the picker never forwarding two consecutive inputs, which holds because `RATE` is above 1. The bench streams samples back to back and with random gaps. It holds full-scale positive and negative constants for thousands of samples, so that the integrators wrap many times while the comb outputs stay within range.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Bits needed to hold the peak gain (base^order) of the cascade
    function automatic int gain_bits(int base, int order);
        longint p;
        p = 1;
        for (int i = 0; i < order; i++) begin
            p = p * longint'(base);
        end
        return $clog2(p);
    endfunction

    typedef enum logic {
        PH_KEEP = 1'b0,
        PH_DROP = 1'b1
    } pick_state_t;

endpackage

// File: rtl/cic_integ_stage.sv
module cic_integ_stage #(
    parameter int W = 17
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vin,
    input  logic signed [W-1:0] din,
    output logic                vout,
    output logic signed [W-1:0] acc
);

    // Modular accumulate: overflow wraps, never saturates (R5)
    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            vout <= 1'b0;
        end else begin
            vout <= vin;
            if (vin) begin
                acc <= acc + din;
            end
        end
    end

    // R2: no sample, no change
    assert_integ_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !vin |=> $stable(acc));

endmodule

// File: rtl/cic_rate_pick.sv
module cic_rate_pick
    import cic_pkg::*;
#(
    parameter int W    = 17,
    parameter int RATE = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vin,
    input  logic signed [W-1:0] din,
    output logic                vout,
    output logic signed [W-1:0] dout
);

    localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATE - 1);

    pick_state_t    st, st_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_KEEP;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            PH_KEEP: begin
                if (vin && (RATE > 1)) begin
                    st_nx  = PH_DROP;
                    cnt_nx = CW'(1);
                end
            end
            PH_DROP: begin
                if (vin) begin
                    if (cnt == LAST) begin
                        st_nx  = PH_KEEP;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_nx  = PH_KEEP;
                cnt_nx = '0;
            end
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            vout <= 1'b0;
            dout <= '0;
        end else begin
            vout <= vin && (st == PH_KEEP);
            if (vin && (st == PH_KEEP)) begin
                dout <= din;
            end
        end
    end

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_keep_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_KEEP) |-> (cnt == '0));

endmodule

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
    parameter int W     = 17,
    parameter int DELAY = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vin,
    input  logic signed [W-1:0] din,
    output logic                vout,
    output logic signed [W-1:0] dout
);

    logic signed [W-1:0] hist [DELAY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DELAY; i++) begin
                hist[i] <= '0;
            end
            dout <= '0;
            vout <= 1'b0;
        end else begin
            vout <= vin;
            if (vin) begin
                dout    <= din - hist[DELAY-1];
                hist[0] <= din;
                for (int i = 1; i < DELAY; i++) begin
                    hist[i] <= hist[i-1];
                end
            end
        end
    end

    // R2/R4: the difference only moves on a reduced-rate sample
    assert_comb_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !vin |=> $stable(dout));

endmodule

// File: rtl/cic_wrap_decim.sv
module cic_wrap_decim
    import cic_pkg::*;
#(
    parameter int ORDER = 3,
    parameter int DELAY = 2,
    parameter int RATE  = 4,
    parameter int IN_W  = 8,
    localparam int ACC_W = IN_W + gain_bits(RATE * DELAY, ORDER)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_smp,
    output logic             out_vld,
    output logic [ACC_W-1:0] out_smp
);

    localparam int EXT = ACC_W - IN_W;

    logic                    i_vld [ORDER+1];
    logic signed [ACC_W-1:0] i_dat [ORDER+1];
    logic                    c_vld [ORDER+1];
    logic signed [ACC_W-1:0] c_dat [ORDER+1];

    // Sign extension of the input word (R7)
    assign i_vld[0] = in_vld;
    assign i_dat[0] = {{EXT{in_smp[IN_W-1]}}, in_smp};

    for (genvar k = 0; k < ORDER; k++) begin : g_integ
        cic_integ_stage #(.W(ACC_W)) u_integ (
            .clk  (clk),
            .rst  (rst),
            .vin  (i_vld[k]),
            .din  (i_dat[k]),
            .vout (i_vld[k+1]),
            .acc  (i_dat[k+1])
        );
    end

    cic_rate_pick #(.W(ACC_W), .RATE(RATE)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .vin  (i_vld[ORDER]),
        .din  (i_dat[ORDER]),
        .vout (c_vld[0]),
        .dout (c_dat[0])
    );

    for (genvar k = 0; k < ORDER; k++) begin : g_comb
        cic_comb_stage #(.W(ACC_W), .DELAY(DELAY)) u_comb (
            .clk  (clk),
            .rst  (rst),
            .vin  (c_vld[k]),
            .din  (c_dat[k]),
            .vout (c_vld[k+1]),
            .dout (c_dat[k+1])
        );
    end

    assign out_vld = c_vld[ORDER];
    assign out_smp = c_dat[ORDER];

    if (RATE > 1) begin : g_pulse_chk
        // R6: a result strobe never lasts two cycles
        assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
            out_vld |=> !out_vld);
    end

endmodule

// File: tb/cic_wrap_decim_tb.sv
`timescale 1ns/1ps
module cic_wrap_decim_tb;

    localparam int ORDER = 3;
    localparam int DELAY = 2;
    localparam int RATE  = 4;
    localparam int IN_W  = 8;
    localparam int ACC_W = 17;              // 8 + log2(8^3)
    localparam longint GAIN = 512;          // (RATE*DELAY)^ORDER

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_vld = 1'b0;
    logic [IN_W-1:0]  in_smp = '0;
    logic             out_vld;
    logic [ACC_W-1:0] out_smp;

    always #2 clk = ~clk;

    cic_wrap_decim #(.ORDER(ORDER), .DELAY(DELAY), .RATE(RATE), .IN_W(IN_W)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
        .out_vld(out_vld), .out_smp(out_smp)
    );

    int     total = 0;
    int     bad   = 0;
    string  cur_req = "R4";
    longint exp_q[$];
    int     n_out = 0;
    longint last_got = 0;

    // Unbounded reference model
    longint m_int  [ORDER];
    longint m_hist [ORDER][DELAY];
    int     m_cnt;

    task automatic model_clear();
        for (int k = 0; k < ORDER; k++) begin
            m_int[k] = 0;
            for (int j = 0; j < DELAY; j++) m_hist[k][j] = 0;
        end
        m_cnt = 0;
        exp_q.delete();
    endtask

    task automatic model_step(longint x);
        longint v;
        longint d;
        v = x;
        for (int k = 0; k < ORDER; k++) begin
            m_int[k] = m_int[k] + v;
            v = m_int[k];
        end
        if (m_cnt == 0) begin
            for (int k = 0; k < ORDER; k++) begin
                d = v - m_hist[k][DELAY-1];
                for (int j = DELAY-1; j > 0; j--) m_hist[k][j] = m_hist[k][j-1];
                m_hist[k][0] = v;
                v = d;
            end
            exp_q.push_back(v);
        end
        m_cnt = (m_cnt + 1) % RATE;
    endtask

    task automatic check(string req, longint got, longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic send(longint x);
        in_vld = 1'b1;
        in_smp = IN_W'(x);
        model_step(x);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        check("R1 out_vld in reset", longint'(out_vld), 0);
        check("R1 out_smp in reset", longint'(out_smp), 0);
        model_clear();
        n_out = 0;
        rst = 1'b0;
        idle(1);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            longint got;
            got = $signed(out_smp);   // R7 signed read
            last_got = got;
            n_out++;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL %s: unexpected output %0d expected none", cur_req, got);
            end else begin
                check(cur_req, got, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        model_clear();
        @(negedge clk);
        do_reset();

        // R6 / R4: impulse latency and first value
        cur_req = "R4 impulse";
        send(1);
        n = 0;
        while (!out_vld && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R6 latency", n, 2 * ORDER);
        check("R4 first impulse output", $signed(out_smp), 1);
        @(negedge clk);
        check("R6 single-cycle strobe", longint'(out_vld), 0);
        for (int i = 0; i < 40; i++) send(0);
        idle(12);

        // R2: random samples with random gaps
        cur_req = "R2 gapped stream";
        for (int i = 0; i < 600; i++) begin
            send(longint'($signed(IN_W'($urandom))));
            idle($urandom_range(0, 3));
        end
        idle(12);

        // R1: reset mid-stream, then back-to-back stream
        cur_req = "R1 after reset";
        for (int i = 0; i < 7; i++) send(50);
        do_reset();
        for (int i = 0; i < 200; i++) send(longint'($signed(IN_W'($urandom))));
        idle(12);

        // R3: output count
        do_reset();
        cur_req = "R3 count";
        for (int i = 0; i < 10; i++) begin
            send(i + 1);
            idle(i % 3);
        end
        idle(20);
        check("R3 outputs for 10 inputs", n_out, 3);
        check("R3 scoreboard drained", exp_q.size(), 0);

        // R5: long full-scale DC forcing integrator wrap
        cur_req = "R5 dc positive";
        for (int i = 0; i < 3000; i++) send(127);
        idle(12);
        check("R5 dc +max gain", last_got, 127 * GAIN);
        cur_req = "R5 dc negative";
        for (int i = 0; i < 3000; i++) send(-128);
        idle(12);
        check("R5 dc -max gain", last_got, -128 * GAIN);
        check("R5 scoreboard drained", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule